// File: doc/BRIEF.md
# Early Branch Resolution Unit

This block settles conditional branches and unconditional jumps while the control instruction sits in the decode stage of a five-stage in-order pipeline. Moving the zero test and the target adder into decode means a taken branch costs one fetch slot instead of three. The condition is a single source register compared against zero, either for equality or for inequality. The target is the decode instruction's sequential PC plus the sign-extended offset, counted in words.

The unit drives the fetch stage's next-PC select. It works under two policies, chosen by a mode input that is sampled in the cycle a control instruction resolves:

- **Squash policy.** Fetch runs on sequentially. The instruction fetched behind a taken branch is cancelled through a flush of the fetch/decode register.
- **Delay policy.** That one following instruction always executes as an architectural delay slot, and the redirect takes effect after it.

A small state machine remembers that the next decode entry is a delay slot or a cancelled bubble. It has three states:

- `ST_SEQ`: normal decode.
- `ST_SLOT`: the next decode entry is a delay slot.
- `ST_BUBBLE`: the next decode entry is a squashed bubble.

Its transitions are:

- `ST_SEQ -> ST_SEQ`: no redirect.
- `ST_SEQ -> ST_BUBBLE`: redirect under the squash policy.
- `ST_SEQ -> ST_SLOT`: redirect under the delay policy.
- `ST_SLOT -> ST_SEQ` and `ST_BUBBLE -> ST_SEQ`: always, after one cycle.

While the machine is in `ST_SLOT` or `ST_BUBBLE`, control instructions in decode are not acted on.

Top module: `ebr_unit`

## Requirements
- R1: Asynchronous active-low reset puts the state machine in ST_SEQ. After reset, a jump in decode redirects at once, even if reset arrived while a bubble was pending.
- R2: Opcode field bits 31:26 select the instruction kind. Value 6'h04 is a branch-if-zero, taken when rs_val equals 0. Value 6'h05 is a branch-if-nonzero, taken when rs_val differs from 0. Any other opcode is not a control instruction.
- R3: A taken branch sets next_pc in the same cycle to id_pc_plus4 plus the immediate in bits 15:0, sign-extended and shifted left by 2. This holds down to the most negative offset.
- R4: With no redirect (branch not taken, id_valid low, or a non-control instruction), redirect is 0 and next_pc equals if_pc_plus4.
- R5: Opcode 6'h02 is a jump and is always taken. Its target is the upper 4 bits of id_pc_plus4, then the 26-bit field in bits 25:0, then two zero bits.
- R6: With policy_delay = 0 (squash), a redirect raises ifid_flush in the same cycle.
- R7: With policy_delay = 1 (delay slot), a redirect leaves ifid_flush low. In the following cycle the delay-slot entry is not acted on as a control instruction: redirect stays 0 and next_pc equals if_pc_plus4.
- R8: Under the squash policy, in the cycle after a redirect, the decode entry is ignored even if id_valid is high and it holds a taken control instruction.
- R9: ST_SLOT and ST_BUBBLE last exactly one cycle. The next control instruction after them resolves normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_delay | input | 1 | 0 selects the squash policy, 1 selects the delay-slot policy |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_instr | input | 32 | Instruction word in decode |
| rs_val | input | XLEN | Source register value read in decode |
| id_pc_plus4 | input | PC_W | Sequential PC of the decode instruction |
| if_pc_plus4 | input | PC_W | Sequential PC of the fetch stage |
| next_pc | output | PC_W | PC for the fetch stage to use next |
| redirect | output | 1 | Control instruction in decode is taken |
| ifid_flush | output | 1 | Cancel the fetch/decode register contents this cycle |

## Verification
The outputs `redirect`, `next_pc` and `ifid_flush` depend combinationally on the decode inputs and the current state, so they are due in the same cycle the stimulus is applied. The state update from a redirect becomes visible one clock edge later, as the ignore behaviour of the next cycle's entry. The bench drives each vector just after the falling edge and samples 2 ns later, well before the rising edge that advances the state. The vector table is ordered so that each slot or bubble row directly follows the redirect that causes it.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 26;
    localparam int IMM_W  = 16;
    localparam int JTGT_W = 26;

    localparam logic [5:0] OPC_BEQZ = 6'h04;
    localparam logic [5:0] OPC_BNEZ = 6'h05;
    localparam logic [5:0] OPC_JMP  = 6'h02;

    typedef enum logic [1:0] {
        ST_SEQ    = 2'd0,
        ST_SLOT   = 2'd1,
        ST_BUBBLE = 2'd2
    } ebr_state_e;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_BEQZ = 2'd1,
        CK_BNEZ = 2'd2,
        CK_JMP  = 2'd3
    } ctl_kind_e;

endpackage

// File: rtl/ebr_decode.sv
module ebr_decode
    import ebr_pkg::*;
(
    input  logic                        valid,
    input  logic [INSN_W-1:0]           instr,
    output ctl_kind_e                   kind,
    output logic [IMM_W-1:0]            imm16,
    output logic [JTGT_W-1:0]           tgt26
);
    logic [OPC_HI-OPC_LO:0] opc;

    assign opc   = instr[OPC_HI:OPC_LO];
    assign tgt26 = instr[JTGT_W-1:0];
    assign imm16 = tgt26[IMM_W-1:0];

    always_comb begin
        kind = CK_NONE;
        if (valid) begin
            unique case (opc)
                OPC_BEQZ: kind = CK_BEQZ;
                OPC_BNEZ: kind = CK_BNEZ;
                OPC_JMP:  kind = CK_JMP;
                default:  kind = CK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ebr_target.sv
module ebr_target
    import ebr_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0]   base_pc,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [JTGT_W-1:0] tgt26,
    output logic [PC_W-1:0]   br_tgt,
    output logic [PC_W-1:0]   jmp_tgt
);
    localparam int EXT_W  = PC_W - IMM_W - 2;
    localparam int JSPAN  = JTGT_W + 2;

    logic [PC_W-1:0] offset;

    assign offset = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};
    assign br_tgt = base_pc + offset;

    generate
        if (PC_W > JSPAN) begin : g_region
            assign jmp_tgt = {base_pc[PC_W-1:JSPAN], tgt26, 2'b00};
        end else begin : g_flat
            logic [JSPAN-1:0] full;
            logic             unused_hi;
            assign full      = {tgt26, 2'b00};
            assign jmp_tgt   = full[PC_W-1:0];
            assign unused_hi = ^{full, base_pc};
        end
    endgenerate
endmodule

// File: rtl/ebr_cond.sv
module ebr_cond
    import ebr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctl_kind_e        kind,
    input  logic [XLEN-1:0]  rs_val,
    output logic             take
);
    logic is_zero;

    assign is_zero = (rs_val == '0);

    always_comb begin
        unique case (kind)
            CK_BEQZ: take = is_zero;
            CK_BNEZ: take = !is_zero;
            CK_JMP:  take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/ebr_fsm.sv
module ebr_fsm
    import ebr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_redirect,
    input  logic delay_mode,
    output logic accept,
    output logic do_flush
);
    ebr_state_e state_q;
    ebr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_SEQ;
        unique case (state_q)
            ST_SEQ: begin
                if (want_redirect) begin
                    state_d = delay_mode ? ST_SLOT : ST_BUBBLE;
                end
            end
            ST_SLOT:   state_d = ST_SEQ;
            ST_BUBBLE: state_d = ST_SEQ;
            default:   state_d = ST_SEQ;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        do_flush = 1'b0;
        unique case (state_q)
            ST_SEQ: begin
                accept   = 1'b1;
                do_flush = want_redirect && !delay_mode;
            end
            ST_SLOT:   accept = 1'b0;
            ST_BUBBLE: accept = 1'b0;
            default:   accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/ebr_unit.sv
module ebr_unit
    import ebr_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              policy_delay,
    input  logic              id_valid,
    input  logic [31:0]       id_instr,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [PC_W-1:0]   id_pc_plus4,
    input  logic [PC_W-1:0]   if_pc_plus4,
    output logic [PC_W-1:0]   next_pc,
    output logic              redirect,
    output logic              ifid_flush
);
    ctl_kind_e          kind;
    logic [IMM_W-1:0]   imm16;
    logic [JTGT_W-1:0]  tgt26;
    logic [PC_W-1:0]    br_tgt;
    logic [PC_W-1:0]    jmp_tgt;
    logic               cond_take;
    logic               accept;
    logic               want;
    logic               flush_w;

    ebr_decode u_dec (
        .valid (id_valid),
        .instr (id_instr),
        .kind  (kind),
        .imm16 (imm16),
        .tgt26 (tgt26)
    );

    ebr_target #(.PC_W(PC_W)) u_tgt (
        .base_pc (id_pc_plus4),
        .imm16   (imm16),
        .tgt26   (tgt26),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    ebr_cond #(.XLEN(XLEN)) u_cond (
        .kind   (kind),
        .rs_val (rs_val),
        .take   (cond_take)
    );

    assign want = cond_take && accept;

    ebr_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .want_redirect (want),
        .delay_mode    (policy_delay),
        .accept        (accept),
        .do_flush      (flush_w)
    );

    always_comb begin
        next_pc = if_pc_plus4;
        if (want) begin
            next_pc = (kind == CK_JMP) ? jmp_tgt : br_tgt;
        end
    end

    assign redirect   = want;
    assign ifid_flush = flush_w;
endmodule

// File: rtl/ebr_unit_chk.sv
module ebr_unit_chk
    import ebr_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              policy_delay,
    input  logic              id_valid,
    input  logic [31:0]       id_instr,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [PC_W-1:0]   id_pc_plus4,
    input  logic [PC_W-1:0]   if_pc_plus4,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              redirect,
    input  logic              ifid_flush
);
    logic            prev_redirect;
    logic [5:0]      opc;
    logic [PC_W-1:0] br_exp;
    logic [PC_W-1:0] jmp_exp;

    assign opc     = id_instr[31:26];
    assign br_exp  = id_pc_plus4 + {{(PC_W-18){id_instr[15]}}, id_instr[15:0], 2'b00};
    assign jmp_exp = {id_pc_plus4[PC_W-1:28], id_instr[25:0], 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_redirect <= 1'b0;
        end else begin
            prev_redirect <= redirect;
        end
    end

    AST_FLUSH_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> redirect); // R6

    AST_DELAY_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && policy_delay) |-> !ifid_flush); // R7

    AST_ONE_SHADOW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect); // R8

    AST_SEQ_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> (next_pc == if_pc_plus4)); // R4

    AST_BEQZ_ZERO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && opc == OPC_BEQZ && rs_val == '0 && !prev_redirect) |-> redirect); // R2

    AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && opc == OPC_JMP && !prev_redirect) |-> (redirect && next_pc == jmp_exp)); // R5

    AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && (opc == OPC_BEQZ || opc == OPC_BNEZ)) |-> (next_pc == br_exp)); // R3
endmodule

bind ebr_unit ebr_unit_chk #(.PC_W(PC_W), .XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_delay (policy_delay),
    .id_valid     (id_valid),
    .id_instr     (id_instr),
    .rs_val       (rs_val),
    .id_pc_plus4  (id_pc_plus4),
    .if_pc_plus4  (if_pc_plus4),
    .next_pc      (next_pc),
    .redirect     (redirect),
    .ifid_flush   (ifid_flush)
);

// File: tb/sim_ebr_unit.sv
module sim_ebr_unit;

    typedef struct packed {
        logic        mode;
        logic        vld;
        logic [31:0] ins;
        logic [31:0] rs;
        logic [31:0] id4;
        logic [31:0] if4;
        logic        tk;
        logic        fl;
        logic [31:0] nx;
    } vec_t;

    localparam int NV = 14;
    // opcodes: 6'h04 branch-if-zero, 6'h05 branch-if-nonzero, 6'h02 jump
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 32'h0022_1820, 32'd0, 32'h100,  32'h104,  1'b0, 1'b0, 32'h104},  // R4 plain op
        '{1'b0, 1'b1, 32'h1060_0010, 32'd5, 32'h104,  32'h108,  1'b0, 1'b0, 32'h108},  // R2 zero-test fails
        '{1'b0, 1'b1, 32'h1060_0010, 32'd0, 32'h108,  32'h10C,  1'b1, 1'b1, 32'h148},  // R2 R3 R6 taken
        '{1'b0, 1'b1, 32'h0800_0100, 32'd0, 32'h10C,  32'h14C,  1'b0, 1'b0, 32'h14C},  // R8 bubble ignored
        '{1'b0, 1'b1, 32'h1440_FFFC, 32'd7, 32'h14C,  32'h150,  1'b1, 1'b1, 32'h13C},  // R9 R2 backward
        '{1'b0, 1'b0, 32'h0022_1820, 32'd0, 32'h150,  32'h140,  1'b0, 1'b0, 32'h140},  // R8 bubble
        '{1'b0, 1'b1, 32'h1440_FFFC, 32'd0, 32'h140,  32'h144,  1'b0, 1'b0, 32'h144},  // R2 nonzero fails
        '{1'b1, 1'b1, 32'h0800_0100, 32'd0, 32'h1004, 32'h1008, 1'b1, 1'b0, 32'h400},  // R5 R7 jump
        '{1'b1, 1'b1, 32'h1060_0010, 32'd0, 32'h1008, 32'h404,  1'b0, 1'b0, 32'h404},  // R7 slot ignored
        '{1'b1, 1'b1, 32'h1060_0010, 32'd0, 32'h404,  32'h408,  1'b1, 1'b0, 32'h444},  // R9 R7 taken
        '{1'b1, 1'b1, 32'h0022_1820, 32'd0, 32'h408,  32'h448,  1'b0, 1'b0, 32'h448},  // R7 slot runs
        '{1'b1, 1'b0, 32'h0800_0100, 32'd0, 32'h448,  32'h44C,  1'b0, 1'b0, 32'h44C},  // R4 invalid
        '{1'b1, 1'b1, 32'h1440_FFFC, 32'd1, 32'h44C,  32'h450,  1'b1, 1'b0, 32'h43C},  // R2 R7 taken
        '{1'b0, 1'b1, 32'h0022_1820, 32'd0, 32'h450,  32'h440,  1'b0, 1'b0, 32'h440}   // R9 slot
    };

    logic        clk;
    logic        rst_n;
    logic        policy_delay;
    logic        id_valid;
    logic [31:0] id_instr;
    logic [31:0] rs_val;
    logic [31:0] id_pc_plus4;
    logic [31:0] if_pc_plus4;
    logic [31:0] next_pc;
    logic        redirect;
    logic        ifid_flush;

    int checks;
    int errors;
    bit finished;

    ebr_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .policy_delay (policy_delay),
        .id_valid     (id_valid),
        .id_instr     (id_instr),
        .rs_val       (rs_val),
        .id_pc_plus4  (id_pc_plus4),
        .if_pc_plus4  (if_pc_plus4),
        .next_pc      (next_pc),
        .redirect     (redirect),
        .ifid_flush   (ifid_flush)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic m, input logic v, input logic [31:0] ins,
                         input logic [31:0] rs, input logic [31:0] i4, input logic [31:0] f4);
        @(negedge clk);
        policy_delay = m;
        id_valid     = v;
        id_instr     = ins;
        rs_val       = rs;
        id_pc_plus4  = i4;
        if_pc_plus4  = f4;
        #2;
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0;
        errors = 0;
        finished = 1'b0;
        rst_n = 1'b0;
        policy_delay = 1'b0;
        id_valid = 1'b0;
        id_instr = '0;
        rs_val = '0;
        id_pc_plus4 = '0;
        if_pc_plus4 = 32'h10;
        #3;
        check("R1 reset redirect", {31'd0, redirect}, 32'd0);
        check("R1 reset next_pc", next_pc, 32'h10);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].mode, VEC[i].vld, VEC[i].ins, VEC[i].rs, VEC[i].id4, VEC[i].if4);
            check($sformatf("R2/R4/R7/R8 table row %0d redirect", i), {31'd0, redirect}, {31'd0, VEC[i].tk});
            check($sformatf("R6/R7 table row %0d flush", i), {31'd0, ifid_flush}, {31'd0, VEC[i].fl});
            check($sformatf("R3/R5/R4 table row %0d next_pc", i), next_pc, VEC[i].nx);
        end

        // R3 most negative offset: 0x20004 - 0x20000
        drive(1'b0, 1'b1, 32'h1060_8000, 32'd0, 32'h0002_0004, 32'h0002_0008);
        check("R3 min offset next_pc", next_pc, 32'h0000_0004);
        check("R6 min offset flush", {31'd0, ifid_flush}, 32'd1);
        drive(1'b0, 1'b0, 32'h0, 32'd0, 32'h0, 32'h0000_0008);
        check("R8 bubble after min offset", next_pc, 32'h0000_0008);

        // R5 jump keeps upper PC region, full 26-bit field
        drive(1'b1, 1'b1, 32'h0BFF_FFFF, 32'd9, 32'hA000_0010, 32'hA000_0014);
        check("R5 jump region target", next_pc, 32'hAFFF_FFFC);
        check("R7 jump no flush", {31'd0, ifid_flush}, 32'd0);
        drive(1'b1, 1'b1, 32'h0022_1820, 32'd0, 32'hA000_0014, 32'hB000_0000);
        check("R9 slot next_pc", next_pc, 32'hB000_0000);

        // R1 reset while a bubble is pending clears it
        drive(1'b0, 1'b1, 32'h1060_0010, 32'd0, 32'h200, 32'h204);
        check("R6 pre-reset taken", {31'd0, redirect}, 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        #2 rst_n = 1'b1;
        policy_delay = 1'b0;
        id_valid = 1'b1;
        id_instr = 32'h0800_0100;
        id_pc_plus4 = 32'h1004;
        if_pc_plus4 = 32'h248;
        #1;
        check("R1 jump right after reset", {31'd0, redirect}, 32'd1);
        check("R1 jump target after reset", next_pc, 32'h400);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule